// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write an external asynchronous 256K x 16 static RAM that has two byte lanes. The host presents one request at a time: a request strobe, a read/write flag, an 18-bit word address, 16 bits of write data and a 2-bit lane mask. The controller answers with a one-clock completion pulse and, for reads, a registered data word.

On the memory side the controller drives the address, the active-low chip select, write strobe and output enable, one active-low enable per byte lane, and a shared 16-bit tri-state data bus. Every phase of an access is held for a number of clock cycles that is fixed at elaboration. The count is the memory's minimum or maximum timing divided by the clock period in nanoseconds, rounded up, and never less than one. The controller also places a turnaround gap after each read so that the memory has let go of the bus before the controller drives it.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and whenever the controller is idle, chip select, write strobe and output enable are high, both lane enables are high, the data bus is not driven and done is low. After reset the read data register is zero.
- R2: A write accepted at a clock edge gives the following sequence. First, one cycle with chip select low and write strobe high. Then the write strobe is low for ceil(max(35, 25) / period) cycles, 4 at 10 ns, with the write data on the bus. Then one hold cycle with the write strobe high and the data still driven. Output enable stays high throughout.
- R3: During an access, mem_be_n[0] (bits 7:0) is low exactly when req_mask[0] was set, and mem_be_n[1] (bits 15:8) is low exactly when req_mask[1] was set. A write changes only the lanes whose mask bit is set. A write with mask 00 leaves the stored word unchanged.
- R4: The address and the lane enables are taken at acceptance and stay stable for as long as chip select is low, including the hold cycle after the write strobe rises.
- R5: A read accepted at a clock edge holds chip select and output enable low, with the write strobe high, for ceil(max(55, 25) / period) cycles, 6 at 10 ns. The bus is sampled into the read data register at the edge that ends this window. A lane whose mask bit is clear reads as zero.
- R6: After a read, output enable and chip select are high for ceil(18 / period) cycles, 2 at 10 ns, before the controller returns to idle. The controller never drives the bus while output enable is low.
- R7: Done is high for exactly one clock, in the first idle cycle after each access. The read data register keeps its value until the next read samples the bus.
- R8: A request is accepted only when the controller is idle. A request raised while an access is in progress is ignored and causes no memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Registered read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 lower, bit 1 upper |
| mem_dq | inout | 16 | Shared tri-state data bus |

## Verification
The in-line assertions check the following on every cycle. The write strobe is low only inside a chip-select window with output enable high. The bus is never driven while output enable is low. The address and lane enables stay stable while chip select is low. The wait counters step down by one each cycle. Done never lasts two cycles. The latched request stays put while the controller is busy. The bench's scenarios are needed for the rest: exact phase lengths, lane merging as seen through later reads, zeroed lanes in the read data, the turnaround before a write that follows a read, and the dropping of a request raised during a busy cycle.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared state type and elaboration-time helpers for the
// asynchronous SRAM controller. Assumes timings and period in whole ns.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_WRECOV,
        ST_RACCESS,
        ST_RTURN
    } seq_state_t;

    // Cycles needed to cover t_ns at the given period, never below one.
    function automatic int wait_cycles(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
// Module: down-counter for wait states. A load sets the count; the count
// then falls by one per cycle and stops at zero. expired is high at zero.
// Assumes load_val is the number of extra cycles the phase lasts.
module sram_wait_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    // Count register: load, else step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R2/R5/R6: every wait phase shortens by exactly one cycle per clock.
    a_r2_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sram_lane_capture.sv
// Module: read-data register for one byte lane. Samples the bus lane on
// capture; a lane outside the request mask is stored as zero.
// Assumes capture falls on the last cycle of the read access window.
module sram_lane_capture #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              lane_on,
    input  logic [LANE_W-1:0] lane_in,
    output logic [LANE_W-1:0] lane_q
);

    // Lane register: sample or zero on capture, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lane_q <= '0;
        else if (capture)
            lane_q <= lane_on ? lane_in : '0;
    end

    // R5: an unselected lane reads back as zero.
    a_r5_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !lane_on) |=> (lane_q == '0));

endmodule

// File: rtl/sram_sequencer.sv
// Module: access sequencer. Latches one request while idle, steps through
// the write or read phases with wait-state counts set at elaboration, and
// drives registered memory strobes so they change only at clock edges.
// Assumes the counts already meet the memory timings at this clock.
module sram_sequencer
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANES  = 2,
    parameter int N_WE   = 4,
    parameter int N_RD   = 6,
    parameter int N_TURN = 2,
    parameter int N_REC  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              done,
    output logic              capture,
    output logic [LANES-1:0]  mask_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              drive_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n
);

    localparam int MAXC     = max_of(max_of(N_WE, N_RD), max_of(N_TURN, N_REC));
    localparam int CW       = $clog2(MAXC + 1);
    localparam int REC_LOAD = (N_REC > 0) ? N_REC - 1 : 0;

    seq_state_t        state, nxt;
    logic              timer_load, timer_zero;
    logic [CW-1:0]     timer_val;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  mask_src;
    logic              accept;

    // Chip select is active in these phases.
    function automatic logic selected(input seq_state_t s);
        return (s == ST_WSETUP) || (s == ST_WPULSE) || (s == ST_WHOLD) || (s == ST_RACCESS);
    endfunction

    assign accept = (state == ST_IDLE) && req_valid;

    // Next-state selection from the current phase and the wait timer.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (req_valid) nxt = req_write ? ST_WSETUP : ST_RACCESS;
            ST_WSETUP:  nxt = ST_WPULSE;
            ST_WPULSE:  if (timer_zero) nxt = ST_WHOLD;
            ST_WHOLD:   nxt = (N_REC > 0) ? ST_WRECOV : ST_IDLE;
            ST_WRECOV:  if (timer_zero) nxt = ST_IDLE;
            ST_RACCESS: if (timer_zero) nxt = ST_RTURN;
            ST_RTURN:   if (timer_zero) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Wait count to load when entering a phase.
    always_comb begin
        case (nxt)
            ST_WPULSE:  timer_val = CW'(N_WE - 1);
            ST_RACCESS: timer_val = CW'(N_RD - 1);
            ST_RTURN:   timer_val = CW'(N_TURN - 1);
            ST_WRECOV:  timer_val = CW'(REC_LOAD);
            default:    timer_val = '0;
        endcase
    end

    assign timer_load = (nxt != state);
    assign capture    = (state == ST_RACCESS) && timer_zero;
    assign mask_src   = (state == ST_IDLE) ? req_mask : mask_q;
    assign mem_addr   = addr_q;

    sram_wait_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_zero)
    );

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Request latch: taken only on acceptance, held through the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    // Memory strobes registered from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_be_n <= '1;
            drive_q  <= 1'b0;
        end else begin
            mem_ce_n <= !selected(nxt);
            mem_we_n <= (nxt != ST_WPULSE);
            mem_oe_n <= (nxt != ST_RACCESS);
            mem_be_n <= selected(nxt) ? ~mask_src : '1;
            drive_q  <= (nxt == ST_WPULSE) || (nxt == ST_WHOLD);
        end
    end

    // Completion pulse on the return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= (state != ST_IDLE) && (nxt == ST_IDLE);
    end

    // R1: idle means every strobe inactive and the bus released.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (mem_ce_n && mem_we_n && mem_oe_n && (mem_be_n == '1) && !drive_q));

    // R2: the write strobe is low only inside a select window with the bus driven.
    a_r2_we_framed: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && drive_q));

    // R6: no contention; the controller never drives while the memory may.
    a_r6_no_drive_oe: assert property (@(posedge clk) disable iff (!rst_n)
        drive_q |-> mem_oe_n);

    // R4: address and lane enables stable while selected.
    a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

    // R7: done is a single-cycle pulse.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a busy controller does not take a new request.
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (addr_q == $past(addr_q) && mask_q == $past(mask_q)));

endmodule

// File: rtl/sram_async_ctrl.sv
// Module: top of the asynchronous SRAM controller. Derives wait-state
// counts from the clock period and memory timings, runs the sequencer,
// captures read lanes and drives the shared tri-state data bus.
// Assumes DATA_W is a whole number of bytes and timings are in ns.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W           = 18,
    parameter int DATA_W           = 16,
    parameter int CLK_PERIOD_NS    = 10,
    parameter int T_WE_PULSE_NS    = 35,
    parameter int T_DATA_SETUP_NS  = 25,
    parameter int T_WRITE_CYCLE_NS = 45,
    parameter int T_ADDR_ACCESS_NS = 55,
    parameter int T_OE_ACCESS_NS   = 25,
    parameter int T_OE_RELEASE_NS  = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic                done,
    output logic [DATA_W-1:0]   rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_ce_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic [DATA_W/8-1:0] mem_be_n,
    inout  wire  [DATA_W-1:0]   mem_dq
);

    localparam int LANES  = DATA_W / 8;
    localparam int N_WE   = wait_cycles(max_of(T_WE_PULSE_NS, T_DATA_SETUP_NS), CLK_PERIOD_NS);
    localparam int N_RD   = wait_cycles(max_of(T_ADDR_ACCESS_NS, T_OE_ACCESS_NS), CLK_PERIOD_NS);
    localparam int N_TURN = wait_cycles(T_OE_RELEASE_NS, CLK_PERIOD_NS);
    localparam int N_WC   = wait_cycles(T_WRITE_CYCLE_NS, CLK_PERIOD_NS);
    localparam int N_REC  = (N_WC > N_WE + 2) ? N_WC - N_WE - 2 : 0;

    logic              capture;
    logic              drive_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] wdata_q;

    sram_sequencer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .N_WE   (N_WE),
        .N_RD   (N_RD),
        .N_TURN (N_TURN),
        .N_REC  (N_REC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .done      (done),
        .capture   (capture),
        .mask_q    (mask_q),
        .wdata_q   (wdata_q),
        .drive_q   (drive_q),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_be_n  (mem_be_n)
    );

    // Bus driver: write data during the strobe and hold phases only.
    assign mem_dq = drive_q ? wdata_q : {DATA_W{1'bz}};

    // One read-capture register per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_capture #(.LANE_W(8)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .capture (capture),
            .lane_on (mask_q[g]),
            .lane_in (mem_dq[8*g +: 8]),
            .lane_q  (rdata[8*g +: 8])
        );
    end

endmodule

// File: tb/sram_async_ctrl_test.sv
// Bench: emulated asynchronous SRAM on the bus, plus a queue-based
// reference of the expected pin values per cycle, compared every clock.
module sram_async_ctrl_test;

    // Expected phase lengths at 10 ns: ceil(35/10), ceil(55/10), ceil(18/10).
    localparam int E_WE   = 4;
    localparam int E_RD   = 6;
    localparam int E_TURN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        done;
    logic [15:0] rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_be_n;
    wire  [15:0] mem_dq;

    int checks = 0;
    int fails = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    sram_async_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq(mem_dq)
    );

    // ---------------- emulated memory ----------------
    logic [15:0] cells [int];
    logic [15:0] ref_cells [int];
    int          dev_writes = 0;
    logic [15:0] dev_q;
    logic [15:0] wv;

    function automatic logic [15:0] fill(input logic [17:0] a);
        return {a[7:0] ^ 8'hA1, a[15:8] ^ 8'h3C};
    endfunction

    function automatic logic [15:0] dev_read(input logic [17:0] a);
        return cells.exists(int'(a)) ? cells[int'(a)] : fill(a);
    endfunction

    function automatic logic [15:0] ref_read(input logic [17:0] a);
        return ref_cells.exists(int'(a)) ? ref_cells[int'(a)] : fill(a);
    endfunction

    always @(mem_addr or dev_writes) dev_q = dev_read(mem_addr);

    wire dev_rd_on = rst_n && !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq = {(dev_rd_on && !mem_be_n[1]) ? dev_q[15:8] : 8'hzz,
                     (dev_rd_on && !mem_be_n[0]) ? dev_q[7:0]  : 8'hzz};

    // The write ends when the strobe rises; merge the enabled lanes.
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n) begin
            wv = dev_read(mem_addr);
            if (!mem_be_n[0]) wv[7:0]  = mem_dq[7:0];
            if (!mem_be_n[1]) wv[15:8] = mem_dq[15:8];
            cells[int'(mem_addr)] = wv;
            dev_writes++;
        end
    end

    // ---------------- reference model ----------------
    typedef struct packed {
        logic        ce_n;
        logic        we_n;
        logic        oe_n;
        logic [1:0]  be_n;
        logic        drive;
        logic        done;
        logic        ld_rd;
        logic [15:0] data;
        logic [17:0] addr;
        logic [2:0]  tag;
    } exp_t;

    localparam exp_t IDLE_EXP = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, be_n: 2'b11,
                                  drive: 1'b0, done: 1'b0, ld_rd: 1'b0, data: '0,
                                  addr: '0, tag: 3'd1};

    exp_t        q[$];
    exp_t        e;
    int          acc_count = 0;
    bit          rst_seen = 0;
    logic [15:0] exp_rd = '0;
    logic [15:0] mv;

    function automatic string tag_name(input logic [2:0] t);
        case (t)
            3'd2: return "R2";
            3'd5: return "R5";
            3'd6: return "R6";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, expv, $time);
        end
    endtask

    // Accept a request only when no access is pending, and queue its pin sequence.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            rst_seen = 1;
        end else begin
            if (q.size() > 0) void'(q.pop_front());
            if (q.size() == 0 && req_valid) begin
                acc_count++;
                e = IDLE_EXP;
                e.addr = req_addr;
                if (req_write) begin
                    e.tag = 3'd2; e.ce_n = 1'b0; e.be_n = ~req_mask;
                    q.push_back(e);
                    e.we_n = 1'b0; e.drive = 1'b1; e.data = req_wdata;
                    for (int i = 0; i < E_WE; i++) q.push_back(e);
                    e.we_n = 1'b1;
                    q.push_back(e);
                    mv = ref_read(req_addr);
                    if (req_mask[0]) mv[7:0]  = req_wdata[7:0];
                    if (req_mask[1]) mv[15:8] = req_wdata[15:8];
                    ref_cells[int'(req_addr)] = mv;
                end else begin
                    e.tag = 3'd5; e.ce_n = 1'b0; e.oe_n = 1'b0; e.be_n = ~req_mask;
                    for (int i = 0; i < E_RD; i++) q.push_back(e);
                    mv = ref_read(req_addr);
                    e = IDLE_EXP;
                    e.tag = 3'd6;
                    e.ld_rd = 1'b1;
                    e.data = {req_mask[1] ? mv[15:8] : 8'h00, req_mask[0] ? mv[7:0] : 8'h00};
                    q.push_back(e);
                    e.ld_rd = 1'b0;
                    for (int i = 1; i < E_TURN; i++) q.push_back(e);
                end
                e = IDLE_EXP;
                e.done = 1'b1;
                q.push_back(e);
            end
        end
    end

    // Compare every pin against the reference, mid-cycle.
    always @(negedge clk) begin
        if (rst_seen && !ended) begin
            e = (q.size() > 0) ? q[0] : IDLE_EXP;
            if (e.ld_rd) exp_rd = e.data;
            chk(mem_ce_n == e.ce_n, tag_name(e.tag), 32'(mem_ce_n), 32'(e.ce_n));
            chk(mem_we_n == e.we_n, tag_name(e.tag), 32'(mem_we_n), 32'(e.we_n));
            chk(mem_oe_n == e.oe_n, tag_name(e.tag), 32'(mem_oe_n), 32'(e.oe_n));
            chk(mem_be_n == e.be_n, "R3 lane enables", 32'(mem_be_n), 32'(e.be_n));
            chk(done == e.done, "R7 done pulse", 32'(done), 32'(e.done));
            chk(rdata == exp_rd, "R7 read data held", 32'(rdata), 32'(exp_rd));
            if (!e.ce_n) chk(mem_addr == e.addr, "R4 address", 32'(mem_addr), 32'(e.addr));
            if (e.drive) chk(mem_dq == e.data, "R2 bus data", 32'(mem_dq), 32'(e.data));
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        int start;
        start = acc_count;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        while (acc_count == start) @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic read_check(input logic [17:0] a, input logic [1:0] m, input logic [15:0] expv, input string tag);
        access(1'b0, a, 16'h0000, m);
        wait_idle();
        chk(rdata == expv, tag, 32'(rdata), 32'(expv));
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog expired act=%0d exp=0", q.size());
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !done && rdata == 16'h0,
            "R1 reset state", 32'({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, done}), 32'h3E);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 / R5: full-word write, then full read.
        access(1'b1, 18'h00010, 16'hA5C3, 2'b11);
        read_check(18'h00010, 2'b11, 16'hA5C3, "R5 full read after R2 write");

        // R3: single-lane writes merge into the stored word.
        access(1'b1, 18'h00010, 16'h1177, 2'b01);
        read_check(18'h00010, 2'b11, 16'hA577, "R3 lower lane write");
        access(1'b1, 18'h00010, 16'h2BFF, 2'b10);
        read_check(18'h00010, 2'b11, 16'h2B77, "R3 upper lane write");

        // R5: unselected lanes return zero.
        read_check(18'h00010, 2'b01, 16'h0077, "R5 lower lane read");
        read_check(18'h00010, 2'b10, 16'h2B00, "R5 upper lane read");
        read_check(18'h00010, 2'b00, 16'h0000, "R5 empty mask read");

        // R3: mask 00 write changes nothing.
        access(1'b1, 18'h00010, 16'hFFFF, 2'b00);
        read_check(18'h00010, 2'b11, 16'h2B77, "R3 empty mask write");

        // R4: top address, untouched word then written word.
        read_check(18'h3FFFF, 2'b11, fill(18'h3FFFF), "R4 top address unwritten");
        access(1'b1, 18'h3FFFF, 16'h0F0F, 2'b11);
        read_check(18'h3FFFF, 2'b11, 16'h0F0F, "R4 top address written");

        // R6: read followed at once by a write, then read-back.
        access(1'b0, 18'h00010, 16'h0000, 2'b11);
        access(1'b1, 18'h00030, 16'h4321, 2'b11);
        access(1'b0, 18'h00030, 16'h0000, 2'b11);
        wait_idle();
        chk(rdata == 16'h4321, "R6 write after read", 32'(rdata), 32'h4321);

        // R8: a request raised mid-access is dropped.
        access(1'b1, 18'h00040, 16'hAAAA, 2'b11);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00050; req_wdata = 16'h5555; req_mask = 2'b11;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        read_check(18'h00050, 2'b11, fill(18'h00050), "R8 busy request ignored");
        read_check(18'h00040, 2'b11, 16'hAAAA, "R8 first request kept");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule